// File: doc/BRIEF.md
# Static Memory Wait-State Controller

This block runs single read and write accesses from an on-chip requester to banks of external asynchronous static memory. Each bank has its own chip select and its own wait-state count, supplied on a static configuration port. The controller holds chip select, address and the strobes for the length of an access. It drives the data bus only while a write is in progress, and it returns read data together with a one-cycle completion pulse.

A slow device can stretch an access with an active-low wait input. The input passes through a two-stage synchroniser, so the controller sees an assertion two cycles late. The controller holds the wait phase until two things are true: the programmed count has elapsed, and the device has released the wait input. It then finishes with a fixed three-cycle tail. For a stretch to take effect, a device with N wait states must assert the wait input no later than access cycle N. The cycle in which chip select first drops counts as cycle 1.

Requests are taken only while `ready_o` is high. The requester holds `req_i` high for one cycle at most and waits for `done_o` before it issues the next access.

Top module: `smc_wait_ctrl`

## Requirements
- R1: While `rst_ni` is low, every chip select, `mem_oe_no` and `mem_we_no` is high, `done_o` is low and `ready_o` is high.
- R2: During an access only the chip select whose bit index equals the latched `req_bank_i` is low, and it stays low for cycles 1..T. Cycle 1 is the cycle after the clock edge that accepted the request. T is the access length.
- R3: The effective count N of bank b is taken from `ws_cfg_i[b*5 +: 5]`. With the wait input high throughout, an access lasts T = N + 3 cycles.
- R4: Let m be the first access cycle at or after cycle N in which `mem_wait_ni` is high at the closing clock edge. The access lasts T = m + 3 cycles. A wait input held low from a cycle at or before N through cycle m−1 therefore extends the access.
- R5: A wait assertion that starts only after cycle N does not lengthen the access (T = N + 3).
- R6: `done_o` is high for exactly one cycle, which is cycle T, the last cycle with chip select low.
- R7: On a read, `mem_oe_no` is low and `mem_we_no` is high for cycles 1..T. `rdata_o` in cycle T equals the bus value at the clock edge that ends cycle T−1.
- R8: On a write, `mem_we_no` is low for cycles 1..T−1 and high in cycle T, and `mem_oe_no` stays high. The bus carries the write data in every cycle from 1 to T.
- R9: `mem_addr_o` equals the request address in every cycle from 1 to T.
- R10: `ready_o` is low in cycles 1..T. A request presented while `ready_o` is low is ignored and starts no access.
- R11: Configured counts of 0 and 1 behave as a count of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while ready_o is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| req_bank_i | input | BANK_W | Bank index |
| ws_cfg_i | input | NUM_BANKS*WS_W | Per-bank wait-state counts, bank b at bits b*WS_W upward |
| rdata_o | output | DATA_W | Read data, valid while done_o is high after a read |
| done_o | output | 1 | One-cycle completion pulse |
| ready_o | output | 1 | Controller idle, request can be taken |
| mem_cs_no | output | NUM_BANKS | Chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | ADDR_W | External address |
| mem_data_io | inout | DATA_W | External data bus |
| mem_wait_ni | input | 1 | External wait, active low |

## Verification
The assertions assume that the configuration port stays still during an access and that a device drives the data bus only while output enable is low. They also assume that the wait input eventually releases, since the length rule counts only from that release. The stimulus writes the configuration once, after reset. Its memory model drives the bus only on a read strobe. Every wait pulse it generates is a single low window that ends a bounded number of cycles after chip select drops. The window opens either within the programmed count or after it, and the bench predicts the length for both cases.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_LAST = 2'd2
  } smc_state_e;

  localparam int unsigned WS_MIN = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/smc_wait_sync.sv
module smc_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_ni,
  output logic wait_ok_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= wait_ni;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign wait_ok_o = sync_q[STAGES-1];

  // R4
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_ni |=> !sync_q[0]);
endmodule

// File: rtl/smc_bank_cfg.sv
module smc_bank_cfg
  import smc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned WS_W      = 5,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS*WS_W-1:0] ws_cfg_i,
  input  logic [BANK_W-1:0]         bank_i,
  output logic [WS_W-1:0]           ws_o
);
  logic [WS_W-1:0] ws_arr [NUM_BANKS];
  logic [WS_W-1:0] ws_raw;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
    assign ws_arr[b] = ws_cfg_i[b*WS_W +: WS_W];
  end

  always_comb begin
    ws_raw = ws_arr[0];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_i == BANK_W'(b)) ws_raw = ws_arr[b];
    end
  end

  // R11: counts below the minimum cannot honour a stretch
  assign ws_o = (ws_raw < WS_W'(WS_MIN)) ? WS_W'(WS_MIN) : ws_raw;

  // R11
  ws_floor_chk: assert final (ws_o >= WS_W'(WS_MIN));
endmodule

// File: rtl/smc_cs_decode.sv
module smc_cs_decode #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 active_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] cs_no
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_no[b] = !(active_i && (bank_i == BANK_W'(b)));
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WS_W      = 5,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned CNT_W    = WS_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic              wait_ok_i,
  input  logic [DATA_W-1:0] bus_rd_i,
  output logic              active_o,
  output logic              wr_o,
  output logic              we_phase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              ready_o
);
  smc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WS_W-1:0]   ws_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  exit_thr;
  logic              cnt_max;
  logic              exit_c;

  // the sync delay is folded into the threshold: cycle c sees the pin of cycle c-2
  assign exit_thr = CNT_W'(ws_q) + CNT_W'(SYNC_STAGES);
  assign cnt_max  = &cnt_q;
  assign exit_c   = (cnt_q >= exit_thr) && wait_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ws_q    <= WS_W'(WS_MIN);
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      bank_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            state_q <= ST_ACT;
            cnt_q   <= CNT_W'(1);
            ws_q    <= ws_i;
            we_q    <= req_we_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            bank_q  <= req_bank_i;
          end
        end
        ST_ACT: begin
          if (!cnt_max) cnt_q <= cnt_q + CNT_W'(1);
          if (exit_c) begin
            state_q <= ST_LAST;
            if (!we_q) rdata_q <= bus_rd_i;
          end
        end
        ST_LAST: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o   = (state_q != ST_IDLE);
  assign wr_o       = active_o && we_q;
  assign we_phase_o = (state_q == ST_ACT) && we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign bank_o     = bank_q;
  assign rdata_o    = rdata_q;
  assign done_o     = (state_q == ST_LAST);
  assign ready_o    = (state_q == ST_IDLE);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q >= exit_thr + CNT_W'(1)));

  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && !wait_ok_i) |=> (state_q == ST_ACT));

  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/smc_wait_ctrl.sv
module smc_wait_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WS_W      = 5,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      req_we_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  input  logic [BANK_W-1:0]         req_bank_i,
  input  logic [NUM_BANKS*WS_W-1:0] ws_cfg_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      done_o,
  output logic                      ready_o,
  output logic [NUM_BANKS-1:0]      mem_cs_no,
  output logic                      mem_oe_no,
  output logic                      mem_we_no,
  output logic [ADDR_W-1:0]         mem_addr_o,
  inout  wire  [DATA_W-1:0]         mem_data_io,
  input  logic                      mem_wait_ni
);
  logic              wait_ok;
  logic [WS_W-1:0]   ws_sel;
  logic              active;
  logic              wr;
  logic              we_phase;
  logic [DATA_W-1:0] wdata;
  logic [BANK_W-1:0] bank;

  smc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_ni   (mem_wait_ni),
    .wait_ok_o (wait_ok)
  );

  smc_bank_cfg #(.NUM_BANKS(NUM_BANKS), .WS_W(WS_W)) u_cfg (
    .ws_cfg_i (ws_cfg_i),
    .bank_i   (req_bank_i),
    .ws_o     (ws_sel)
  );

  smc_seq #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WS_W      (WS_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_bank_i  (req_bank_i),
    .ws_i        (ws_sel),
    .wait_ok_i   (wait_ok),
    .bus_rd_i    (mem_data_io),
    .active_o    (active),
    .wr_o        (wr),
    .we_phase_o  (we_phase),
    .addr_o      (mem_addr_o),
    .wdata_o     (wdata),
    .bank_o      (bank),
    .rdata_o     (rdata_o),
    .done_o      (done_o),
    .ready_o     (ready_o)
  );

  smc_cs_decode #(.NUM_BANKS(NUM_BANKS)) u_cs (
    .active_i (active),
    .bank_i   (bank),
    .cs_no    (mem_cs_no)
  );

  assign mem_oe_no   = !(active && !wr);
  assign mem_we_no   = !we_phase;
  assign mem_data_io = wr ? wdata : 'z;

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R8
  we_under_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_cs_no != '1));

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> ($stable(mem_addr_o) && $stable(mem_cs_no)));
endmodule

// File: tb/smc_wait_ctrl_bench.sv
module smc_wait_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 5;

  typedef struct {
    bit    we;
    int    bank;
    int    addr;
    int    data;
    int    len;
    string tag;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [1:0]    req_bank_i = '0;
  logic [NB*WW-1:0] ws_cfg_i;
  logic [DW-1:0] rdata_o;
  logic          done_o, ready_o;
  logic [NB-1:0] mem_cs_no;
  logic          mem_oe_no, mem_we_no;
  logic [AW-1:0] mem_addr_o;
  wire  [DW-1:0] mem_data_io;
  logic          mem_wait_ni = 1'b1;

  int checks = 0;
  int fails = 0;
  int issued = 0;
  int completed = 0;
  int wlo = 0, whi = 0;
  int cfg [NB];
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  item_t q[$];

  // bank 0: 2, bank 1: 5, bank 2: 0 (acts as 2), bank 3: 31
  initial begin
    cfg[0] = 2; cfg[1] = 5; cfg[2] = 0; cfg[3] = 31;
  end
  assign ws_cfg_i = {WW'(31), WW'(0), WW'(5), WW'(2)};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  smc_wait_ctrl u_smc_wait_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_bank_i(req_bank_i),
    .ws_cfg_i(ws_cfg_i), .rdata_o(rdata_o), .done_o(done_o), .ready_o(ready_o),
    .mem_cs_no(mem_cs_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_addr_o(mem_addr_o), .mem_data_io(mem_data_io), .mem_wait_ni(mem_wait_ni)
  );

  wire cs_any = (mem_cs_no != '1);
  assign mem_data_io = (cs_any && !mem_oe_no) ? mem[mem_addr_o[7:0]] : 'z;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = DW'(16'h1000 + i * 3);
      shadow[i] = DW'(16'h1000 + i * 3);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(int ws, int lo, int hi);
    int n = (ws < 2) ? 2 : ws;
    int m = (lo <= n && n < hi) ? hi : n;
    return m + 3;
  endfunction

  // memory write capture and wait generation, one step per cycle
  int wcyc = 0;
  always @(negedge clk_i) begin
    if (cs_any) begin
      if (!mem_we_no) mem[mem_addr_o[7:0]] <= mem_data_io;
      wcyc = wcyc + 1;
      mem_wait_ni <= !(wcyc >= wlo && wcyc < whi);
    end else begin
      wcyc = 0;
      mem_wait_ni <= 1'b1;
    end
  end

  // monitor / scoreboard
  int  len = 0;
  bit  addr_err, cs_err, stb_err, bus_err, rdy_err, done_early;
  bit  prev_done = 0;
  initial begin
    item_t e;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (prev_done) chk(done_o == 1'b0, "R6", "done low after last cycle", done_o, 0);
      prev_done = done_o;
      if (cs_any && q.size() > 0) begin
        e = q[0];
        len++;
        if (mem_addr_o != AW'(e.addr)) addr_err = 1;
        if (mem_cs_no != ~(NB'(1) << e.bank)) cs_err = 1;
        if (ready_o) rdy_err = 1;
        if (done_o && len != e.len) done_early = 1;
        if (e.we) begin
          if (mem_oe_no != 1'b1) stb_err = 1;
          if (mem_we_no != ((len < e.len) ? 1'b0 : 1'b1)) stb_err = 1;
          if (mem_data_io != DW'(e.data)) bus_err = 1;
        end else begin
          if (mem_oe_no != 1'b0 || mem_we_no != 1'b1) stb_err = 1;
        end
        if (done_o) begin
          void'(q.pop_front());
          completed++;
          chk(len == e.len, e.tag, "access length", len, e.len);
          chk(!done_early, "R6", "done in last cycle only", done_early, 0);
          chk(!cs_err, "R2", "single bank select", cs_err, 0);
          chk(!addr_err, "R9", "address held", addr_err, 0);
          chk(!rdy_err, "R10", "ready low while busy", rdy_err, 0);
          if (e.we) begin
            chk(!stb_err, "R8", "write strobes", stb_err, 0);
            chk(!bus_err, "R8", "write data on bus", bus_err, 0);
          end else begin
            chk(!stb_err, "R7", "read strobes", stb_err, 0);
            chk(rdata_o == DW'(e.data), "R7", "read data", int'(rdata_o), e.data);
          end
          len = 0;
          {addr_err, cs_err, stb_err, bus_err, rdy_err, done_early} = '0;
        end
      end else if (done_o) begin
        chk(0, "R6", "done with no access", 1, 0);
      end
    end
  end

  task automatic issue(bit we, int bank, int addr, int data, int lo, int hi, string tag);
    item_t e;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    wlo = lo; whi = hi;
    e.we = we; e.bank = bank; e.addr = addr; e.len = exp_len(cfg[bank], lo, hi); e.tag = tag;
    if (we) begin
      e.data = data;
      shadow[addr[7:0]] = DW'(data);
    end else begin
      e.data = int'(shadow[addr[7:0]]);
    end
    q.push_back(e);
    issued++;
    req_i = 1'b1; req_we_i = we; req_bank_i = 2'(bank);
    req_addr_i = AW'(addr); req_wdata_i = DW'(data);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", issued - completed, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(mem_cs_no == '1, "R1", "chip selects idle", int'(mem_cs_no), 15);
    chk(mem_oe_no && mem_we_no, "R1", "strobes idle", {mem_oe_no, mem_we_no}, 3);
    chk(ready_o == 1'b1, "R1", "ready in reset", ready_o, 1);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    issue(1, 0, 16'h10, 16'hA5A5, 0, 0, "R3");   // T=5
    issue(0, 0, 16'h10, 0, 0, 0, "R3");
    issue(1, 1, 16'h21, 16'h3C3C, 0, 0, "R3");   // T=8
    issue(0, 1, 16'h21, 0, 2, 9, "R4");          // N=5 -> T=12
    issue(0, 0, 16'h10, 0, 2, 6, "R4");          // N=2, asserted in cycle 2 -> T=9
    issue(1, 1, 16'h22, 16'h0F0F, 4, 12, "R4");  // T=15
    issue(0, 0, 16'h05, 0, 3, 8, "R5");          // after N=2 -> T=5
    issue(0, 1, 16'h22, 0, 6, 10, "R5");         // after N=5 -> T=8
    issue(1, 2, 16'h40, 16'h7777, 0, 0, "R11");  // cfg 0 -> T=5
    issue(0, 2, 16'h40, 0, 2, 5, "R11");         // T=8
    issue(1, 3, 16'h50, 16'h1234, 0, 0, "R3");   // T=34
    issue(0, 3, 16'h50, 0, 10, 40, "R4");        // T=43

    // R10: requests during a busy access are ignored
    fork
      issue(0, 1, 16'h60, 0, 0, 0, "R3");
      begin
        repeat (3) @(negedge clk_i);
        req_i = 1'b1; req_we_i = 1'b1; req_bank_i = 2'd0;
        req_addr_i = 16'h33; req_wdata_i = 16'hDEAD;
        @(negedge clk_i);
        req_i = 1'b0;
      end
    join
    issue(0, 0, 16'h33, 0, 0, 0, "R10");         // must return original content

    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(completed == issued, "R10", "completed access count", completed, issued);
    chk(mem_cs_no == '1 && ready_o, "R10", "idle after run", int'(mem_cs_no), 15);
    finish_run();
  end
endmodule